// File: doc/BRIEF.md
# Mailbox Sequence Host Engine

This block is the host-side master for a command mailbox that is reached through a 32-bit register bus. The mailbox has two registers. One is an interface register, at offset 0x00, that carries an opcode and a run/busy flag. The other is a data register, at offset 0x04, that carries the argument and the result. A client hands the engine one request. The request selects the space (CSR or MMIO) and the direction (read or write), and carries an address and write data. The engine turns the request into a bracketed sequence of mailbox commands. It opens the sequence, sends the register address, moves the data, reads the data register once, and closes the sequence.

Each command is sent as a pair of writes. The engine then polls the run/busy flag with a fixed wait between reads, and re-sends the whole command a bounded number of times if it does not succeed. The wait is counted in clock cycles from a clock-frequency parameter. A failed command raises an error flag, and the sequence still goes on with the next command. A read-modify-write request runs a full read sequence. It then runs a full write sequence whose data is the value read, ANDed with one mask and ORed with another.

Top module: `mbx_seq_engine`

## Requirements
- R1: Each command is sent as two bus writes. The first writes the argument to offset 0x04. The next bus access writes offset 0x00 with bit 31 set, bits 30..8 zero and the 8-bit opcode in bits 7..0.
- R2: After the interface write, the engine reads offset 0x00. While bit 31 reads set, it reads again after a wait of at least GAP_CYCLES = (CLK_HZ/1e6)*GAP_US cycles. It makes at most POLL_MAX reads per attempt (default 100).
- R3: A command succeeds when a poll returns bit 31 clear and bits 15..0 equal to 0x0040. A timeout or any other code re-sends both writes of the command. There are at most TRY_MAX attempts per command (default 10).
- R4: When all TRY_MAX attempts of a command fail, the error flag is set and the sequence continues with its next command.
- R5: The commands of a sequence run in this order. First comes open (opcode 0x02), with the sequence ID as argument. Then the register opcode, with the address. Then the data opcode, with the write data (zero for reads). Then one bus read of offset 0x04. Then close (opcode 0x03), with the sequence ID.
- R6: The request kind sets the sequence ID, register opcode and data opcode. CSR read: 1, 0x13, 0x07. CSR write: 2, 0x14, 0x08. MMIO read: 3, 0x15, 0x07. MMIO write: 4, 0x16, 0x08.
- R7: `rdata` presents the value read from offset 0x04 in the fetch step. It is valid in the cycle `done` is high.
- R8: A read-modify-write runs the read sequence and then the write sequence. The write data is (read value AND `req_and`) OR `req_or`. `rdata` returns the value from the read pass, and `done` comes only after the second close.
- R9: `req_ready` is high only while the engine is idle. A request is taken when `req_valid` and `req_ready` are both high. `req_valid` while busy has no effect.
- R10: `done` is a one-cycle pulse that follows completion of the final close command.
- R11: `err` stays set for the rest of the current request once any command fails. It is cleared when the next request is accepted.
- R12: After reset, `req_ready` is 1, and `done`, `err` and `bus_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_mmio | input | 1 | 1 selects MMIO space, 0 selects CSR space |
| req_write | input | 1 | 1 for write, 0 for read |
| req_rmw | input | 1 | Read-modify-write (overrides req_write) |
| req_addr | input | DW | Target address |
| req_wdata | input | DW | Write data |
| req_and | input | DW | AND mask for read-modify-write |
| req_or | input | DW | OR mask for read-modify-write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky command-failure flag for this request |
| rdata | output | DW | Value read from the data register |
| bus_valid | output | 1 | Bus access request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | AW | Register offset |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Access completes on this cycle |
| bus_rdata | input | DW | Read data, valid with bus_ready on reads |

## Verification
The assertions assume three things about the bus. `bus_ready` is asserted only while `bus_valid` is high. Read data is valid in the same cycle as `bus_ready`. The mailbox status word keeps its response code in bits 15..0 and its run flag in bit 31. The bench's target model raises ready only in response to a pending access, with random stalls. It answers polls with a configurable number of busy reads, and it injects stuck-busy or illegal-code faults on one chosen opcode. This keeps every exchange inside that contract while still driving the retry and error paths.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [7:0] OP_OPEN     = 8'h02;
  localparam logic [7:0] OP_CLOSE    = 8'h03;
  localparam logic [7:0] OP_RD_DATA  = 8'h07;
  localparam logic [7:0] OP_WR_DATA  = 8'h08;
  localparam logic [7:0] OP_RD_CSR   = 8'h13;
  localparam logic [7:0] OP_WR_CSR   = 8'h14;
  localparam logic [7:0] OP_RD_MMIO  = 8'h15;
  localparam logic [7:0] OP_WR_MMIO  = 8'h16;

  localparam logic [7:0]  OFS_IFC  = 8'h00;
  localparam logic [7:0]  OFS_DATA = 8'h04;
  localparam logic [15:0] RESP_OK  = 16'h0040;

  typedef enum logic [2:0] {
    SP_OPEN, SP_REG, SP_DATA, SP_FETCH, SP_CLOSE
  } step_e;

  function automatic logic [7:0] reg_opcode(logic mmio, logic wr);
    if (mmio) return wr ? OP_WR_MMIO : OP_RD_MMIO;
    return wr ? OP_WR_CSR : OP_RD_CSR;
  endfunction

  function automatic logic [7:0] data_opcode(logic wr);
    return wr ? OP_WR_DATA : OP_RD_DATA;
  endfunction

  function automatic logic [2:0] seq_code(logic mmio, logic wr);
    return 3'({mmio, wr}) + 3'd1;
  endfunction

  function automatic step_e step_next(step_e s);
    case (s)
      SP_OPEN:  return SP_REG;
      SP_REG:   return SP_DATA;
      SP_DATA:  return SP_FETCH;
      SP_FETCH: return SP_CLOSE;
      default:  return SP_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/mbx_gap_timer.sv
module mbx_gap_timer #(
  parameter int GAP_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int GW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);

  logic [GW-1:0] cnt;
  logic          run;

  assign expired = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= GW'(GAP_CYCLES - 1);
      run <= 1'b1;
    end else if (expired) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_expire_single_r2: assert property (@(posedge clk) disable iff (rst)
    expired && !start |=> !expired);

endmodule

// File: rtl/mbx_cmd_unit.sv
module mbx_cmd_unit
  import mbx_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter int POLL_MAX   = 100,
  parameter int TRY_MAX    = 10,
  parameter int GAP_CYCLES = 1250
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fetch,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] arg,
  output logic          fin,
  output logic          fail,
  output logic [DW-1:0] rd_val,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int TW = $clog2(TRY_MAX + 1);

  typedef enum logic [2:0] {
    C_IDLE, C_WDATA, C_WIFC, C_POLL, C_GAP, C_FETCH
  } cst_e;

  cst_e          state, nxt;
  logic [PW-1:0] polls;
  logic [TW-1:0] tries;
  logic [7:0]    opc_q;
  logic [DW-1:0] arg_q;
  logic          fin_n, fail_n, retry_n, gap_go, gap_hit;
  logic          st_busy, st_ok;

  assign st_busy = bus_rdata[DW-1];
  assign st_ok   = (bus_rdata[15:0] == RESP_OK);

  mbx_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .start   (gap_go),
    .expired (gap_hit)
  );

  always_comb begin
    nxt     = state;
    fin_n   = 1'b0;
    fail_n  = 1'b0;
    retry_n = 1'b0;
    gap_go  = 1'b0;
    case (state)
      C_IDLE:  if (start) nxt = fetch ? C_FETCH : C_WDATA;
      C_WDATA: if (bus_ready) nxt = C_WIFC;
      C_WIFC:  if (bus_ready) nxt = C_POLL;
      C_POLL: begin
        if (bus_ready) begin
          if (!st_busy && st_ok) begin
            nxt   = C_IDLE;
            fin_n = 1'b1;
          end else if (st_busy && (int'(polls) + 1 < POLL_MAX)) begin
            nxt    = C_GAP;
            gap_go = 1'b1;
          end else if (int'(tries) >= TRY_MAX) begin
            nxt    = C_IDLE;
            fin_n  = 1'b1;
            fail_n = 1'b1;
          end else begin
            nxt     = C_WDATA;
            retry_n = 1'b1;
          end
        end
      end
      C_GAP:   if (gap_hit) nxt = C_POLL;
      C_FETCH: begin
        if (bus_ready) begin
          nxt   = C_IDLE;
          fin_n = 1'b1;
        end
      end
      default: nxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= C_IDLE;
      fin       <= 1'b0;
      fail      <= 1'b0;
      polls     <= '0;
      tries     <= '0;
      opc_q     <= '0;
      arg_q     <= '0;
      rd_val    <= '0;
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      state <= nxt;
      fin   <= fin_n;
      fail  <= fail_n;
      if (state == C_IDLE && start) begin
        opc_q <= opcode;
        arg_q <= arg;
        tries <= TW'(1);
      end else if (retry_n) begin
        tries <= tries + 1'b1;
      end
      if (state == C_WIFC) polls <= '0;
      else if (state == C_POLL && bus_ready) polls <= polls + 1'b1;
      if (state == C_FETCH && bus_ready) rd_val <= bus_rdata;
      bus_valid <= (nxt == C_WDATA) || (nxt == C_WIFC) ||
                   (nxt == C_POLL)  || (nxt == C_FETCH);
      bus_we    <= (nxt == C_WDATA) || (nxt == C_WIFC);
      bus_addr  <= ((nxt == C_WIFC) || (nxt == C_POLL)) ? AW'(OFS_IFC) : AW'(OFS_DATA);
      if (nxt == C_WIFC)
        bus_wdata <= {1'b1, {(DW-9){1'b0}}, opc_q};
      else if (nxt == C_WDATA)
        bus_wdata <= (state == C_IDLE) ? arg : arg_q;
      else
        bus_wdata <= '0;
    end
  end

  p_ifc_follows_data_r1: assert property (@(posedge clk) disable iff (rst)
    (state == C_WDATA && bus_ready) |=>
      (bus_valid && bus_we && bus_addr == AW'(OFS_IFC) && bus_wdata[DW-1]));

  p_poll_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (state == C_POLL) |-> (int'(polls) < POLL_MAX));

  p_resend_on_bad_code_r3: assert property (@(posedge clk) disable iff (rst)
    (state == C_POLL && bus_ready && !st_busy && !st_ok && int'(tries) < TRY_MAX) |=>
      (bus_valid && bus_we && bus_addr == AW'(OFS_DATA)));

  p_bus_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

endmodule

// File: rtl/mbx_seq_ctrl.sv
module mbx_seq_ctrl
  import mbx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_mmio,
  input  logic          req_write,
  input  logic          req_rmw,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_and,
  input  logic [DW-1:0] req_or,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          cmd_start,
  output logic          cmd_fetch,
  output logic [7:0]    cmd_op,
  output logic [DW-1:0] cmd_arg,
  input  logic          cmd_fin,
  input  logic          cmd_fail,
  input  logic [DW-1:0] cmd_rd
);
  logic          busy, pass_wr, rmw_q, mmio_q;
  step_e         step;
  logic [DW-1:0] addr_q, wdata_q, and_q, or_q, rd_q;

  assign req_ready = !busy;
  assign cmd_fetch = (step == SP_FETCH);

  always_comb begin
    cmd_op  = OP_OPEN;
    cmd_arg = DW'(seq_code(mmio_q, pass_wr));
    case (step)
      SP_REG: begin
        cmd_op  = reg_opcode(mmio_q, pass_wr);
        cmd_arg = addr_q;
      end
      SP_DATA: begin
        cmd_op  = data_opcode(pass_wr);
        cmd_arg = pass_wr ? wdata_q : '0;
      end
      SP_FETCH: begin
        cmd_op  = OP_RD_DATA;
        cmd_arg = '0;
      end
      SP_CLOSE: cmd_op = OP_CLOSE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pass_wr   <= 1'b0;
      rmw_q     <= 1'b0;
      mmio_q    <= 1'b0;
      step      <= SP_OPEN;
      addr_q    <= '0;
      wdata_q   <= '0;
      and_q     <= '0;
      or_q      <= '0;
      rd_q      <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      cmd_start <= 1'b0;
    end else begin
      done      <= 1'b0;
      cmd_start <= 1'b0;
      if (!busy && req_valid) begin
        busy      <= 1'b1;
        step      <= SP_OPEN;
        pass_wr   <= req_write && !req_rmw;
        rmw_q     <= req_rmw;
        mmio_q    <= req_mmio;
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
        and_q     <= req_and;
        or_q      <= req_or;
        err       <= 1'b0;
        cmd_start <= 1'b1;
      end else if (busy && cmd_fin) begin
        if (cmd_fail) err <= 1'b1;
        if (step == SP_FETCH && !(rmw_q && pass_wr)) rd_q <= cmd_rd;
        if (step != SP_CLOSE) begin
          step      <= step_next(step);
          cmd_start <= 1'b1;
        end else if (rmw_q && !pass_wr) begin
          pass_wr   <= 1'b1;
          wdata_q   <= (rd_q & and_q) | or_q;
          step      <= SP_OPEN;
          cmd_start <= 1'b1;
        end else begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rdata <= rd_q;
        end
      end
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_err_cleared_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !err);

  p_fail_sets_err_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_fin && cmd_fail) |=> err);

  p_single_launch_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);

endmodule

// File: rtl/mbx_seq_engine.sv
module mbx_seq_engine #(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int CLK_HZ   = 125_000_000,
  parameter int GAP_US   = 10,
  parameter int POLL_MAX = 100,
  parameter int TRY_MAX  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_mmio,
  input  logic          req_write,
  input  logic          req_rmw,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_and,
  input  logic [DW-1:0] req_or,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);
  localparam int GAP_RAW    = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int GAP_CYCLES = (GAP_RAW < 1) ? 1 : GAP_RAW;

  logic          cmd_start, cmd_fetch, cmd_fin, cmd_fail;
  logic [7:0]    cmd_op;
  logic [DW-1:0] cmd_arg, cmd_rd;

  mbx_seq_ctrl #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mmio  (req_mmio),
    .req_write (req_write),
    .req_rmw   (req_rmw),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_and   (req_and),
    .req_or    (req_or),
    .done      (done),
    .err       (err),
    .rdata     (rdata),
    .cmd_start (cmd_start),
    .cmd_fetch (cmd_fetch),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .cmd_fin   (cmd_fin),
    .cmd_fail  (cmd_fail),
    .cmd_rd    (cmd_rd)
  );

  mbx_cmd_unit #(
    .DW(DW), .AW(AW), .POLL_MAX(POLL_MAX), .TRY_MAX(TRY_MAX), .GAP_CYCLES(GAP_CYCLES)
  ) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .start     (cmd_start),
    .fetch     (cmd_fetch),
    .opcode    (cmd_op),
    .arg       (cmd_arg),
    .fin       (cmd_fin),
    .fail      (cmd_fail),
    .rd_val    (cmd_rd),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata)
  );

  p_idle_no_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid && !done) |=> !bus_valid || !req_ready);

endmodule

// File: tb/sim_mbx_seq_engine.sv
module sim_mbx_seq_engine;
  localparam int GAP  = 10;
  localparam int POLL = 5;
  localparam int TRY  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_mmio = 1'b0, req_write = 1'b0, req_rmw = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, req_and = '0, req_or = '0;
  logic        req_ready, done, err;
  logic [31:0] rdata;
  logic        bus_valid, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready = 1'b0;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mbx_seq_engine #(
    .DW(32), .AW(8), .CLK_HZ(1_000_000), .GAP_US(10), .POLL_MAX(POLL), .TRY_MAX(TRY)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mmio(req_mmio), .req_write(req_write), .req_rmw(req_rmw),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_and(req_and), .req_or(req_or),
    .done(done), .err(err), .rdata(rdata),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  // ---------------- mailbox target model ----------------
  logic [31:0] dreg = '0;
  int          busy_left = 0;
  bit          stuck = 0;
  logic [15:0] resp = 16'h0040;
  logic [31:0] tmem_csr [16] = '{default: 32'h0};
  logic [31:0] tmem_mmio[16] = '{default: 32'h0};
  logic [3:0]  tgt_addr = '0;
  bit          tgt_mmio = 0;
  int          busy_polls = 0;
  logic [7:0]  fault_op = 8'h00;
  int          fault_left = 0;
  bit          fault_illegal = 0;
  logic [7:0]  log_op [256];
  logic [31:0] log_arg[256];
  int          log_n = 0, attempts = 0;
  int          v_frame = 0, v_gap = 0, v_poll = 0;
  bit          prev_data_wr = 0, prev_poll = 0;
  int          last_poll = 0, polls_this = 0, cyc = 0;

  assign bus_rdata = (bus_addr == 8'h04) ? dreg :
                     ((stuck || busy_left > 0) ? 32'h8000_0000 : {16'h0, resp});

  always @(negedge clk) bus_ready <= bus_valid && ($urandom % 3 != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && bus_valid && bus_ready) begin
      if (bus_we && bus_addr == 8'h04) begin
        dreg <= bus_wdata; prev_data_wr <= 1; prev_poll <= 0;
      end else if (bus_we && bus_addr == 8'h00) begin
        attempts <= attempts + 1; prev_poll <= 0; polls_this <= 0; prev_data_wr <= 0;
        if (!prev_data_wr || !bus_wdata[31] || bus_wdata[30:8] != 0) v_frame <= v_frame + 1;
        busy_left <= busy_polls;
        if (fault_left > 0 && bus_wdata[7:0] == fault_op) begin
          fault_left <= fault_left - 1;
          stuck <= !fault_illegal;
          resp  <= 16'h0090;
        end else begin
          stuck <= 0;
          resp  <= 16'h0040;
          log_op[log_n]  <= bus_wdata[7:0];
          log_arg[log_n] <= dreg;
          log_n <= log_n + 1;
          case (bus_wdata[7:0])
            8'h13, 8'h14: begin tgt_addr <= dreg[3:0]; tgt_mmio <= 0; end
            8'h15, 8'h16: begin tgt_addr <= dreg[3:0]; tgt_mmio <= 1; end
            8'h07: dreg <= tgt_mmio ? tmem_mmio[tgt_addr] : tmem_csr[tgt_addr];
            8'h08: if (tgt_mmio) tmem_mmio[tgt_addr] <= dreg; else tmem_csr[tgt_addr] <= dreg;
            default: ;
          endcase
        end
      end else if (!bus_we && bus_addr == 8'h00) begin
        polls_this <= polls_this + 1;
        if (polls_this + 1 > POLL) v_poll <= v_poll + 1;
        if (prev_poll && (cyc - last_poll) < GAP) v_gap <= v_gap + 1;
        prev_poll <= 1; last_poll <= cyc;
        if (busy_left > 0) busy_left <= busy_left - 1;
      end else begin
        prev_poll <= 0; prev_data_wr <= 0;
      end
    end
  end

  // ---------------- bench reference ----------------
  logic [31:0] ref_csr [16] = '{default: 32'h0};
  logic [31:0] ref_mmio[16] = '{default: 32'h0};
  logic [7:0]  exp_op [32];
  logic [31:0] exp_arg[32];
  int          exp_n = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic push(logic [7:0] op, logic [31:0] a, logic [7:0] skip);
    if (op != skip) begin
      exp_op[exp_n] = op; exp_arg[exp_n] = a; exp_n++;
    end
  endtask

  // R5/R6: open(seq), register op(addr), data op(data or 0), close(seq)
  task automatic build_exp(bit mmio, bit wr, logic [31:0] a, logic [31:0] d, logic [7:0] skip);
    logic [31:0] sid;
    logic [7:0]  rop;
    sid = mmio ? (wr ? 32'd4 : 32'd3) : (wr ? 32'd2 : 32'd1);
    rop = mmio ? (wr ? 8'h16 : 8'h15) : (wr ? 8'h14 : 8'h13);
    push(8'h02, sid, skip);
    push(rop, a, skip);
    push(wr ? 8'h08 : 8'h07, wr ? d : 32'h0, skip);
    push(8'h03, sid, skip);
  endtask

  task automatic run_req(bit mmio, bit wr, bit rmw, logic [31:0] a, logic [31:0] wd,
                         logic [31:0] am, logic [31:0] om, bit exp_err, int extra,
                         logic [7:0] skip, bit chk_rd, bit poke);
    int base_n, base_att, vf, vg, vp, wait_c;
    logic [31:0] old, nv, exp_rd, got_rd;
    bit got_err, match;
    base_n = log_n; base_att = attempts; vf = v_frame; vg = v_gap; vp = v_poll;
    old = mmio ? ref_mmio[a[3:0]] : ref_csr[a[3:0]];
    nv  = rmw ? ((old & am) | om) : (wr ? wd : old);
    exp_rd = (wr && !rmw) ? wd : old;
    exp_n = 0;
    if (rmw) begin
      build_exp(mmio, 0, a, 0, skip);
      build_exp(mmio, 1, a, nv, skip);
    end else begin
      build_exp(mmio, wr, a, wd, skip);
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_mmio = mmio; req_write = wr; req_rmw = rmw;
    req_addr = a; req_wdata = wd; req_and = am; req_or = om;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R9", {31'h0, req_ready}, 32'h0, "ready after accept");
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1; req_mmio = !mmio; req_write = 1; req_rmw = 0;
      req_addr = a ^ 32'h5; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      req_valid = 0;
    end
    wait_c = 0;
    while (!done && wait_c < 20000) begin @(negedge clk); wait_c++; end
    got_rd = rdata; got_err = err;
    check(done, "R10", {31'h0, done}, 32'h1, "done seen");
    @(negedge clk);
    check(!done, "R10", {31'h0, done}, 32'h0, "done one cycle");
    check(got_err == exp_err, exp_err ? "R4" : "R11", {31'h0, got_err}, {31'h0, exp_err}, "err flag");
    if (chk_rd) check(got_rd == exp_rd, rmw ? "R8" : "R7", got_rd, exp_rd, "rdata");
    check(log_n - base_n == exp_n, "R5", 32'(log_n - base_n), 32'(exp_n), "command count");
    match = 1;
    for (int i = 0; i < exp_n; i++)
      if (log_op[base_n + i] != exp_op[i] || log_arg[base_n + i] != exp_arg[i]) match = 0;
    check(match, "R6", {24'h0, log_op[base_n]}, {24'h0, exp_op[0]}, "opcode/arg sequence");
    check(attempts - base_att == exp_n + extra, "R3", 32'(attempts - base_att),
          32'(exp_n + extra), "attempts");
    check(v_frame == vf, "R1", 32'(v_frame - vf), 0, "framing violations");
    check(v_gap == vg && v_poll == vp, "R2", 32'(v_gap - vg + v_poll - vp), 0, "poll gap/bound");
    if (skip == 8'h00) begin
      if (mmio) ref_mmio[a[3:0]] = nv; else ref_csr[a[3:0]] = nv;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready && !done && !err && !bus_valid, "R12",
          {28'h0, req_ready, done, err, bus_valid}, 32'h8, "reset state");

    // directed: plain accesses of each kind, R6
    run_req(0, 1, 0, 32'h0000_0003, 32'hA5A5_0001, 0, 0, 0, 0, 8'h00, 1, 0);
    run_req(0, 0, 0, 32'h0000_0003, 0, 0, 0, 0, 0, 8'h00, 1, 0);
    run_req(1, 1, 0, 32'h1000_0007, 32'h1234_5678, 0, 0, 0, 0, 8'h00, 1, 0);
    run_req(1, 0, 0, 32'h1000_0007, 0, 0, 0, 0, 0, 8'h00, 1, 0);

    // R8: read-modify-write, then confirm by reading back
    run_req(1, 0, 1, 32'h0000_0007, 0, 32'hFFFF_00FF, 32'h0000_3300, 0, 0, 8'h00, 1, 0);
    run_req(1, 0, 0, 32'h0000_0007, 0, 0, 0, 0, 0, 8'h00, 1, 0);

    // R2: long busy periods within the poll bound
    busy_polls = POLL - 1;
    run_req(0, 0, 0, 32'h0000_0003, 0, 0, 0, 0, 0, 8'h00, 1, 0);
    busy_polls = 0;

    // R3: illegal code twice on the write-data command, recovers
    fault_op = 8'h08; fault_illegal = 1; fault_left = TRY - 1;
    run_req(1, 1, 0, 32'h0000_0009, 32'h0BAD_F00D, 0, 0, 0, TRY - 1, 8'h00, 1, 0);
    // R3: stuck busy once on open, recovers
    fault_op = 8'h02; fault_illegal = 0; fault_left = 1;
    run_req(0, 0, 0, 32'h0000_0009, 0, 0, 0, 0, 1, 8'h00, 1, 0);

    // R4: register command never completes, sequence continues, err set
    fault_op = 8'h13; fault_illegal = 0; fault_left = TRY;
    run_req(0, 0, 0, 32'h0000_0002, 0, 0, 0, 1, TRY, 8'h13, 0, 0);
    // R11: err cleared by next accepted request
    run_req(0, 0, 0, 32'h0000_0002, 0, 0, 0, 0, 0, 8'h00, 1, 0);

    // R9: request while busy is ignored; idle engine stays off the bus
    run_req(0, 1, 0, 32'h0000_000C, 32'h7777_0000, 0, 0, 0, 0, 8'h00, 1, 1);
    begin
      int n0, busy_seen;
      n0 = attempts; busy_seen = 0;
      repeat (40) begin @(negedge clk); if (bus_valid) busy_seen++; end
      check(busy_seen == 0 && attempts == n0, "R9", 32'(busy_seen), 0, "no traffic when idle");
    end
    run_req(1, 0, 0, 32'h0000_0009, 0, 0, 0, 0, 0, 8'h00, 1, 0);

    // random mix
    for (int k = 0; k < 24; k++) begin
      bit m, w, r;
      m = 1'($urandom); w = 1'($urandom); r = ($urandom % 4 == 0);
      busy_polls = $urandom % POLL;
      run_req(m, w, r, {$urandom % 256, 4'($urandom)} , $urandom, $urandom, $urandom,
              0, 0, 8'h00, 1, 0);
    end
    finish_run();
  end

endmodule